// File: doc/BRIEF.md
# Serial Configuration EEPROM Word Reader

This block is a hardware master that fetches one 16-bit word from a three-wire serial configuration EEPROM. The EEPROM has a chip select, a serial clock, a serial data line into the memory and a serial data line out of it. A host raises `start_i` for one cycle with a 6-bit word address on `addr_i`. The block then runs the whole transaction on its own. It asserts chip select, shifts out a three-bit read command followed by the address, and clocks in sixteen data bits. It then releases chip select and issues one trailing clock pulse to close the access. At the end it presents the word on `word_o` and pulses `done_o`.

Every serial clock level lasts one dwell of `DWELL_CYC` system clock cycles. By default the dwell is derived from the system clock frequency, giving about nine microseconds per level, so the slowest parts meet their clock-level and data-setup minimums. The request side is a plain pulse interface. A request is taken on any cycle in which `start_i` is high and `busy_o` is low. A request made while `busy_o` is high is dropped, not held. The result side has no back-pressure: `done_o` is a one-cycle strobe, and `word_o` keeps the value it shows during that strobe until the next request is taken.

Top module: `cfg_rom_reader`

## Requirements
- R1: Out of reset, and whenever `busy_o` is low, chip select, serial clock and serial data-in are all low, and `done_o` is low except for its strobe.
- R2: A request taken at a clock edge makes `busy_o` high after that edge. Chip select rises while the serial clock is low and stays high for one full dwell before the first clock rise.
- R3: While chip select is high, the first nine serial clock rises carry, on data-in, the read command 1,1,0 and then the six address bits, most significant bit first. Data-in is set up one dwell before each rise and does not change while the clock is high. The address used is the one present at the accepting edge.
- R4: Data-in is low at every clock rise after the ninth, and whenever chip select is low.
- R5: Every serial clock high level lasts exactly `DWELL_CYC` cycles, and every low level between two rises lasts at least `DWELL_CYC` cycles.
- R6: Sixteen data bits are read on the clock rises that follow the address, one per rise. Each bit is sampled at the end of its high level, and the bits are assembled most significant bit first into `word_o`.
- R7: After the sixteenth data bit's low level, chip select falls while the clock is low. After one more low dwell, exactly one full clock high/low cycle is issued with chip select low.
- R8: `done_o` is high for exactly one cycle, 55 x `DWELL_CYC` cycles after the accepting edge, in the first cycle in which `busy_o` is low. `word_o` then holds until the next request is taken.
- R9: `start_i` pulses while `busy_o` is high, up to and including its last busy cycle, do not change the transaction in flight, its result or its timing, and start no second transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Read request pulse, taken when `busy_o` is low |
| addr_i | input | ADDR_W | Word address, sampled with the request |
| busy_o | output | 1 | High from the accepting edge until the transaction ends |
| done_o | output | 1 | One-cycle strobe marking `word_o` valid |
| word_o | output | DATA_W | Word read from the EEPROM |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |

## Verification
A wrong step or bit count inside the sequencer shows at the pins within one dwell. It appears as a wrong number of clock rises under chip select, a misplaced command or address bit, a chip-select edge that lands on a high clock, or a clock level of the wrong length. The bench therefore counts the rises per transaction, decodes the command and address the memory model received, and times every clock level at the pins. A lost or shifted data bit shows only at the strobe, as a wrong word. A fault in the end-of-transaction logic shows as a shifted `done_o` latency or a stuck `busy_o` on the very transaction where it occurs.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] RD_OP = 3'b110;

  // One entry per serial dwell; each non-idle step lasts exactly one dwell.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,   // select up, clock low, before any edge
    ST_TX_LO,   // outgoing bit presented, clock low
    ST_TX_HI,   // outgoing bit held, clock high
    ST_GAP,     // data-in returned to zero, clock low
    ST_RX_HI,   // clock high, memory bit sampled at the end
    ST_RX_LO,   // clock low between data bits
    ST_DROP,    // select released, clock low
    ST_TR_HI,   // trailing pulse high
    ST_TR_LO    // trailing pulse low
  } step_e;

  function automatic logic step_sel(input step_e s);
    return s inside {ST_SETUP, ST_TX_LO, ST_TX_HI, ST_GAP, ST_RX_HI, ST_RX_LO};
  endfunction

  function automatic logic step_clk(input step_e s);
    return s inside {ST_TX_HI, ST_RX_HI, ST_TR_HI};
  endfunction

  function automatic logic step_drive(input step_e s);
    return s inside {ST_TX_LO, ST_TX_HI};
  endfunction

endpackage

// File: rtl/crr_dwell_timer.sv
module crr_dwell_timer #(
  parameter int DWELL_CYC = 2250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(DWELL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DWELL_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/crr_tx_shift.sv
module crr_tx_shift #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  output logic         msb
);
  logic [W-1:0] sr;

  assign msb = sr[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (load) begin
      sr <= load_val;
    end else if (adv) begin
      sr <= {sr[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/crr_rx_shift.sv
module crr_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (take) begin
      word <= {word[W-2:0], bit_in};
    end
  end
endmodule

// File: rtl/crr_seq.sv
module crr_seq
  import cfg_rom_pkg::*;
#(
  parameter int TX_W = 9,
  parameter int RX_W = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  tick,
  output step_e step,
  output logic  accept,
  output logic  tx_adv,
  output logic  rx_take,
  output logic  done
);
  localparam int MAXB = (TX_W > RX_W) ? TX_W : RX_W;
  localparam int BW   = $clog2(MAXB);

  logic [BW-1:0] bits_left;

  assign accept  = (step == ST_IDLE) && start;
  assign tx_adv  = tick && (step == ST_TX_HI);
  assign rx_take = tick && (step == ST_RX_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= ST_IDLE;
      bits_left <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (step)
        ST_IDLE:  if (start) step <= ST_SETUP;
        ST_SETUP: if (tick) begin
          step      <= ST_TX_LO;
          bits_left <= BW'(TX_W - 1);
        end
        ST_TX_LO: if (tick) step <= ST_TX_HI;
        ST_TX_HI: if (tick) begin
          if (bits_left == '0) begin
            step <= ST_GAP;
          end else begin
            step      <= ST_TX_LO;
            bits_left <= bits_left - 1'b1;
          end
        end
        ST_GAP: if (tick) begin
          step      <= ST_RX_HI;
          bits_left <= BW'(RX_W - 1);
        end
        ST_RX_HI: if (tick) step <= ST_RX_LO;
        ST_RX_LO: if (tick) begin
          if (bits_left == '0) begin
            step <= ST_DROP;
          end else begin
            step      <= ST_RX_HI;
            bits_left <= bits_left - 1'b1;
          end
        end
        ST_DROP:  if (tick) step <= ST_TR_HI;
        ST_TR_HI: if (tick) step <= ST_TR_LO;
        ST_TR_LO: if (tick) begin
          step <= ST_IDLE;
          done <= 1'b1;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader
  import cfg_rom_pkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int DWELL_NS  = 9000,
  parameter int DWELL_CYC = CLK_MHZ * DWELL_NS / 1000,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i
);
  localparam int TX_W = OP_W + ADDR_W;

  step_e step;
  logic  tick, accept, tx_adv, rx_take, tx_msb;

  assign busy_o = (step != ST_IDLE);

  crr_dwell_timer #(.DWELL_CYC(DWELL_CYC)) timer_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_o),
    .tick (tick)
  );

  crr_seq #(.TX_W(TX_W), .RX_W(DATA_W)) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .tick   (tick),
    .step   (step),
    .accept (accept),
    .tx_adv (tx_adv),
    .rx_take(rx_take),
    .done   (done_o)
  );

  crr_tx_shift #(.W(TX_W)) tx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_val({RD_OP, addr_i}),
    .adv     (tx_adv),
    .msb     (tx_msb)
  );

  crr_rx_shift #(.W(DATA_W)) rx_i (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (rx_take),
    .bit_in(ee_do_i),
    .word  (word_o)
  );

  assign ee_cs_o = step_sel(step);
  assign ee_sk_o = step_clk(step);
  assign ee_di_o = step_drive(step) & tx_msb;
endmodule

// File: rtl/cfg_rom_reader_chk.sv
module cfg_rom_reader_chk #(
  parameter int DWELL_CYC = 2250
) (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic ee_cs_o,
  input logic ee_sk_o,
  input logic ee_di_o
);
  localparam int HW = $clog2(DWELL_CYC + 2);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
    end else if (ee_sk_o) begin
      hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));

  // R2
  sel_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs_o) |-> !ee_sk_o);

  // R3
  di_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o));

  // R4
  di_off_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs_o |-> !ee_di_o);

  // R5
  high_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk_o |-> (hi_run < HW'(DWELL_CYC)));

  // R5
  high_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk_o) |-> (hi_run == HW'(DWELL_CYC)));

  // R7
  sel_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs_o) |-> !ee_sk_o);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9
  busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

bind cfg_rom_reader cfg_rom_reader_chk #(.DWELL_CYC(DWELL_CYC)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy_o (busy_o),
  .done_o (done_o),
  .ee_cs_o(ee_cs_o),
  .ee_sk_o(ee_sk_o),
  .ee_di_o(ee_di_o)
);

// File: tb/cfg_rom_reader_tb_top.sv
`timescale 1ns/1ps
module cfg_rom_reader_tb_top;
  localparam int D     = 4;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int STEPS = 55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic busy, done, cs, sk, di;
  logic dout = 1'b0;
  logic [DW-1:0] word;

  always #2 clk = ~clk;

  cfg_rom_reader #(.DWELL_CYC(D), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .busy_o(busy), .done_o(done), .word_o(word),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(dout)
  );

  // Behavioural memory model
  logic [DW-1:0] rom [2**AW];
  logic [8:0] cmd;
  int n_sel_edge, n_trail, n_di_bad, n_hi_bad, n_lo_bad, n_rise_bad;

  always @(posedge sk) begin
    if (cs) begin
      if (n_sel_edge < 9) cmd = {cmd[7:0], di};
      else begin
        if (di) n_di_bad++;
        if (n_sel_edge < 25) dout <= rom[cmd[5:0]][24 - n_sel_edge];
      end
      n_sel_edge++;
    end else begin
      n_trail++;
    end
  end

  always @(posedge cs) if (sk) n_rise_bad++;

  // Clock level timing monitor
  int hi_run = 0;
  int lo_run = 1000;
  logic sk_prev = 1'b0;
  always @(negedge clk) begin
    if (sk && !sk_prev && lo_run < D) n_lo_bad++;
    if (!sk && sk_prev && hi_run != D) n_hi_bad++;
    if (sk) begin hi_run++; lo_run = 0; end
    else begin lo_run++; hi_run = 0; end
    sk_prev = sk;
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    n_sel_edge = 0; n_trail = 0; n_di_bad = 0;
    n_hi_bad = 0; n_lo_bad = 0; n_rise_bad = 0; cmd = '0;
  endtask

  task automatic run_read(input logic [AW-1:0] a, input int poke_at,
                          input logic [AW-1:0] poke_a,
                          output logic [DW-1:0] got, output int lat);
    clear_model();
    @(negedge clk); start = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); start = 1'b0; addr = ~a;
    chk("R2 busy after accept", 32'(busy), 32'd1);
    lat = 0;
    while (!done && lat < 100000) begin
      if (lat == poke_at) begin start = 1'b1; addr = poke_a; end
      else start = 1'b0;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    start = 1'b0;
    got = word;
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    logic [DW-1:0] got;
    int lat;
    run_read(a, -1, '0, got, lat);
    chk("R6 word", 32'(got), 32'(rom[a]));
    chk("R3 command and address", 32'(cmd), 32'({3'b110, a}));
    chk("R3 rises under select", 32'(n_sel_edge), 32'd25);
    chk("R4 data-in low after address", 32'(n_di_bad), 32'd0);
    chk("R7 trailing pulses", 32'(n_trail), 32'd1);
    chk("R8 latency", 32'(lat), 32'(STEPS * D));
    chk("R5 high level length", 32'(n_hi_bad), 32'd0);
    chk("R5 low level length", 32'(n_lo_bad), 32'd0);
    chk("R2 select rises with clock low", 32'(n_rise_bad), 32'd0);
    chk("R8 busy low at done", 32'(busy), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 done one cycle", 32'(done), 32'd0);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    chk("R8 word held", 32'(word), 32'(rom[a]));
    chk("R1 idle pins", 32'({cs, sk, di}), 32'd0);
  endtask

  task automatic t_poke(input logic [AW-1:0] a, input int at, input logic [AW-1:0] other);
    logic [DW-1:0] got;
    int lat;
    int extra;
    run_read(a, at, other, got, lat);
    chk("R9 word unaffected", 32'(got), 32'(rom[a]));
    chk("R9 address unaffected", 32'(cmd[5:0]), 32'(a));
    chk("R9 latency unaffected", 32'(lat), 32'(STEPS * D));
    chk("R9 rises unaffected", 32'(n_sel_edge), 32'd25);
    extra = 0;
    repeat (20) begin
      @(posedge clk); @(negedge clk);
      if (busy || done) extra++;
    end
    chk("R9 no second transaction", 32'(extra), 32'd0);
    chk("R9 select stays low", 32'(cs), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) rom[i] = DW'(i * 16'h3B1) ^ 16'hA5C3;
    rom[5] = '0;
    rom[6] = '1;
    clear_model();
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset busy", 32'(busy), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);
    chk("R1 reset pins", 32'({cs, sk, di}), 32'd0);
    t_read(6'd0);
    t_read(6'd63);
    t_read(6'd21);
    t_read(6'd42);
    t_read(6'd5);
    t_read(6'd6);
    t_poke(6'd10, 30, 6'd33);
    t_poke(6'd44, STEPS * D - 1, 6'd1);
    t_read(6'd1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule